// File: doc/BRIEF.md
# Bridge Initiator Termination Sequencer

This block drives the initiator side of a bus bridge. It takes one burst request (direction, start word address, length in data phases), issues it on a parallel bus, and follows the target's answer phase by phase. Each data phase ends in one of four ways: the data moves and the burst goes on, the data moves and the target disconnects, nothing moves and the target asks for a retry, or the phase is aborted. The phase can also be aborted because no device answered (master abort). When the transfer stops early, the sequencer reissues the request itself. After a disconnect it reissues only the unfinished part, at the next word address. After a retry it waits a guard interval and then reissues the same remaining part.

For reads, the block produces a completion stream for the upstream side. It passes through every word the target supplies. If the burst is aborted, it fills every data phase still owed with all-ones words, so the upstream side always receives exactly the requested length. A completion-done strobe then carries one status for the whole packet: success, target abort or master abort. Writes produce only that status strobe. A sticky received-target-abort bit records every target abort. It is cleared by a write-one-to-clear strobe.

The controller has six states:
- IDLE: ready for a request.
- ISSUE: a one-cycle start strobe with the current address and remaining length.
- DATA: target responses are sampled.
- BACKOFF: the retry guard interval.
- PAD: all-ones fill words are emitted.
- DONE: the status strobe is emitted.

The transitions are:
- IDLE→ISSUE when a request is accepted.
- ISSUE→DATA always.
- DATA→DATA on a wait phase or a non-final normal phase.
- DATA→DONE on the final normal phase, on a final disconnect, or on any abort of a write.
- DATA→ISSUE on a non-final disconnect.
- DATA→BACKOFF on a retry.
- DATA→PAD on any abort of a read.
- BACKOFF→ISSUE after the guard interval.
- PAD→PAD while fill words remain.
- PAD→DONE after the last fill word.
- DONE→IDLE always.

Top module: `brg_term_seq`

## Requirements
- R1: After reset the block is idle. `req_ready` is 1, `bus_start`, `bus_busy`, `cpl_valid` and `cpl_done` are 0, and `sta_rx_tabort` is 0.
- R2: A request accepted while `req_ready` is 1 produces, in the next cycle, a one-cycle `bus_start` with `bus_addr` equal to the request address, `bus_len` equal to the request length and `bus_write` equal to the request direction. Response inputs are sampled in the cycles that follow, while `bus_busy` is 1.
- R3: On a read, every phase ended by `tgt_ack` or `tgt_disc` gives `cpl_valid`=1 with `cpl_data`=`rd_data` in that same cycle. A phase with no response input gives no word. The cycle after the last phase gives `cpl_done` with `cpl_status`=0 (success).
- R4: A phase ended by `tgt_disc` transfers its word. If phases remain, the next cycle reissues with `bus_start`, with `bus_addr` advanced by one per word already transferred and `bus_len` equal to the remaining phase count.
- R5: After a `tgt_retry` phase (no data moves), `bus_start` stays 0 for `RETRY_GAP` cycles. The request, unchanged in address and remaining length, is then reissued, as often as the target retries.
- R6: A retry is not an error. It leaves `sta_rx_tabort` unchanged, and the burst still ends with status 0.
- R7: When a read suffers `tgt_abort` on any phase, that phase gives no word. Every phase still owed then gives one all-ones word per cycle, and `cpl_done` follows with status 1 (target abort) for the whole packet.
- R8: Every accepted `tgt_abort`, on a read or a write, sets `sta_rx_tabort`. The bit then holds 1 until it is cleared.
- R9: `sta_rx_tabort` is cleared by a one-cycle `sta_clr_w1c`. If a target abort arrives in the same cycle as the clear, the bit stays set.
- R10: `mst_abort` ends the transfer at once with status 2 (master abort). On a read, all-ones words fill every phase still owed. `sta_rx_tabort` is not changed.
- R11: A write never raises `cpl_valid`. It ends with a single `cpl_done` carrying its status.
- R12: When several response inputs are high in one phase, the priority is `mst_abort`, then `tgt_abort`, then `tgt_retry`, then `tgt_disc`, then `tgt_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | AW | Start word address |
| req_len | input | LW | Burst length in data phases (at least 1) |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| bus_start | output | 1 | Start strobe for a bus transaction |
| bus_addr | output | AW | Address of the issued transaction |
| bus_len | output | LW | Remaining phases of the issued transaction |
| bus_write | output | 1 | Direction of the burst in progress |
| bus_busy | output | 1 | Data phase in progress, responses sampled |
| tgt_ack | input | 1 | Phase completed, burst continues |
| tgt_disc | input | 1 | Phase completed, target disconnects |
| tgt_retry | input | 1 | No data moved, target asks for retry |
| tgt_abort | input | 1 | Target abort on this phase |
| mst_abort | input | 1 | No target responded |
| rd_data | input | DW | Read data of the current phase |
| cpl_valid | output | 1 | Completion word valid |
| cpl_data | output | DW | Completion word |
| cpl_done | output | 1 | Completion status strobe |
| cpl_status | output | 2 | 0 success, 1 target abort, 2 master abort |
| sta_rx_tabort | output | 1 | Sticky received-target-abort bit |
| sta_clr_w1c | input | 1 | Write-one-to-clear for the sticky bit |

## Verification
The bench aims at the points where a careless sequencer loses track of the burst:
- A disconnect in mid-burst is followed by a reissue. A design that forgot to advance the address or shrink the length would re-read words or overrun the request.
- A retry reissues the transfer. Reissuing too early breaks the guard interval, and setting the abort bit turns a retry into an error.
- A target abort after valid data must pad out the rest of the packet with all-ones. A design that stopped the stream short, or reported success, would hand the upstream side a truncated packet. A master abort gets the same treatment, with its own status and without touching the sticky bit.
- The priority of simultaneous responses is checked, and so is a clear that collides with a new abort. A wrong priority would drop an abort that should have been recorded.

// File: rtl/brg_term_pkg.sv
package brg_term_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_ISSUE   = 3'd1,
        S_DATA    = 3'd2,
        S_BACKOFF = 3'd3,
        S_PAD     = 3'd4,
        S_DONE    = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        CPL_OK     = 2'd0,
        CPL_TABORT = 2'd1,
        CPL_MABORT = 2'd2
    } cpl_stat_e;

endpackage

// File: rtl/brg_burst_track.sv
module brg_burst_track #(
    parameter int AW = 16,
    parameter int LW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [LW-1:0] ld_len,
    input  logic          step,
    output logic [AW-1:0] cur_addr,
    output logic [LW-1:0] rem_len,
    output logic          on_last
);
    // Address and remaining length advance together, one word per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem_len  <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            rem_len  <= ld_len;
        end else if (step) begin
            cur_addr <= cur_addr + 1'b1;
            rem_len  <= rem_len - 1'b1;
        end
    end

    assign on_last = (rem_len == LW'(1));
endmodule

// File: rtl/brg_backoff_timer.sv
module brg_backoff_timer #(
    parameter int RETRY_GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int GW = (RETRY_GAP > 1) ? $clog2(RETRY_GAP) : 1;

    logic [GW-1:0] cnt;

    // Counts the cycles spent waiting; cleared whenever the wait is not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (!expired)  cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == GW'(RETRY_GAP - 1));
endmodule

// File: rtl/brg_sticky_bit.sv
module brg_sticky_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // A new set wins over a clear arriving in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/brg_term_seq.sv
module brg_term_seq
    import brg_term_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DW        = 32,
    parameter int LW        = 5,
    parameter int RETRY_GAP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [LW-1:0] req_len,
    output logic          req_ready,
    output logic          bus_start,
    output logic [AW-1:0] bus_addr,
    output logic [LW-1:0] bus_len,
    output logic          bus_write,
    output logic          bus_busy,
    input  logic          tgt_ack,
    input  logic          tgt_disc,
    input  logic          tgt_retry,
    input  logic          tgt_abort,
    input  logic          mst_abort,
    input  logic [DW-1:0] rd_data,
    output logic          cpl_valid,
    output logic [DW-1:0] cpl_data,
    output logic          cpl_done,
    output logic [1:0]    cpl_status,
    output logic          sta_rx_tabort,
    input  logic          sta_clr_w1c
);
    seq_state_e st_q, st_d;
    cpl_stat_e  stat_q, stat_d;
    logic       wr_q;

    logic          load, step, on_last, gap_done;
    logic [AW-1:0] cur_addr;
    logic [LW-1:0] rem_len;

    // Decoded response of the current phase, highest priority first.
    logic in_data, ev_mab, ev_tab, ev_rty, ev_xfer, ev_disc;
    assign in_data = (st_q == S_DATA);
    assign ev_mab  = in_data && mst_abort;
    assign ev_tab  = in_data && !mst_abort && tgt_abort;
    assign ev_rty  = in_data && !mst_abort && !tgt_abort && tgt_retry;
    assign ev_xfer = in_data && !mst_abort && !tgt_abort && !tgt_retry
                     && (tgt_disc || tgt_ack);
    assign ev_disc = ev_xfer && tgt_disc;

    assign load = (st_q == S_IDLE) && req_valid;
    assign step = ev_xfer || (st_q == S_PAD);

    brg_burst_track #(.AW(AW), .LW(LW)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .ld_addr  (req_addr),
        .ld_len   (req_len),
        .step     (step),
        .cur_addr (cur_addr),
        .rem_len  (rem_len),
        .on_last  (on_last)
    );

    brg_backoff_timer #(.RETRY_GAP(RETRY_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == S_BACKOFF),
        .expired (gap_done)
    );

    brg_sticky_bit u_rx_tabort (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ev_tab),
        .clr   (sta_clr_w1c),
        .q     (sta_rx_tabort)
    );

    // State register, burst direction and packet status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= S_IDLE;
            stat_q <= CPL_OK;
            wr_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            stat_q <= stat_d;
            if (load) wr_q <= req_write;
        end
    end

    // Next state and packet status.
    always_comb begin
        st_d   = st_q;
        stat_d = stat_q;
        unique case (st_q)
            S_IDLE: begin
                if (req_valid) begin
                    st_d   = S_ISSUE;
                    stat_d = CPL_OK;
                end
            end
            S_ISSUE: st_d = S_DATA;
            S_DATA: begin
                if (ev_mab || ev_tab) begin
                    stat_d = ev_mab ? CPL_MABORT : CPL_TABORT;
                    st_d   = wr_q ? S_DONE : S_PAD;
                end else if (ev_rty) begin
                    st_d = S_BACKOFF;
                end else if (ev_xfer) begin
                    if (on_last)      st_d = S_DONE;
                    else if (ev_disc) st_d = S_ISSUE;
                end
            end
            S_BACKOFF: if (gap_done) st_d = S_ISSUE;
            S_PAD:     if (on_last)  st_d = S_DONE;
            S_DONE:    st_d = S_IDLE;
            default:   st_d = S_IDLE;
        endcase
    end

    // Outputs.
    always_comb begin
        req_ready  = (st_q == S_IDLE);
        bus_start  = (st_q == S_ISSUE);
        bus_busy   = in_data;
        bus_addr   = cur_addr;
        bus_len    = rem_len;
        bus_write  = wr_q;
        cpl_valid  = (ev_xfer && !wr_q) || (st_q == S_PAD);
        cpl_data   = (st_q == S_PAD) ? '1 : rd_data;
        cpl_done   = (st_q == S_DONE);
        cpl_status = stat_q;
    end
endmodule

// File: rtl/brg_term_chk.sv
module brg_term_chk #(
    parameter int RETRY_GAP = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       bus_start,
    input logic       bus_busy,
    input logic       bus_write,
    input logic       tgt_retry,
    input logic       tgt_abort,
    input logic       mst_abort,
    input logic       cpl_valid,
    input logic       cpl_done,
    input logic [1:0] cpl_status,
    input logic       sta_rx_tabort,
    input logic       sta_clr_w1c
);
    logic       armed;
    logic [7:0] since_rty;
    logic       rty_seen;

    assign rty_seen = bus_busy && tgt_retry && !tgt_abort && !mst_abort;

    // Counts cycles from an accepted retry to the following start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            since_rty <= '0;
        end else if (rty_seen) begin
            armed     <= 1'b1;
            since_rty <= '0;
        end else begin
            if (bus_start) armed <= 1'b0;
            if (since_rty != 8'hFF) since_rty <= since_rty + 1'b1;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_busy && !cpl_valid && !cpl_done));

    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_start |=> (!bus_start && bus_busy));

    p_retry_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && armed) |-> (since_rty >= 8'(RETRY_GAP)));

    p_retry_noerr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rty_seen && !sta_rx_tabort) |=> !sta_rx_tabort);

    p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sta_rx_tabort && !sta_clr_w1c) |=> sta_rx_tabort);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && tgt_abort && !mst_abort) |=> sta_rx_tabort);

    p_mab_nosticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && mst_abort && !sta_rx_tabort) |=> !sta_rx_tabort);

    p_write_nodata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_busy && bus_write) |-> !cpl_valid);

    p_status_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_done |-> (cpl_status != 2'd3));
endmodule

bind brg_term_seq brg_term_chk #(.RETRY_GAP(RETRY_GAP)) u_chk (.*);

// File: tb/tb_brg_term_seq.sv
module tb_brg_term_seq;
    localparam int AW = 16, DW = 32, LW = 5, GAP = 2;
    localparam logic [DW-1:0] ONES = '1;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_len = '0;
    logic          req_ready, bus_start, bus_write, bus_busy;
    logic [AW-1:0] bus_addr;
    logic [LW-1:0] bus_len;
    logic          tgt_ack = 0, tgt_disc = 0, tgt_retry = 0, tgt_abort = 0, mst_abort = 0;
    logic [DW-1:0] rd_data = '0;
    logic          cpl_valid, cpl_done, sta_rx_tabort, sta_clr_w1c = 0;
    logic [DW-1:0] cpl_data;
    logic [1:0]    cpl_status;

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    brg_term_seq #(.AW(AW), .DW(DW), .LW(LW), .RETRY_GAP(GAP)) dut (.*);

    // Phase kinds
    localparam int K_ACK = 0, K_DISC = 1, K_RTY = 2, K_TAB = 3, K_MAB = 4,
                   K_WAIT = 5, K_TAB_DISC = 6, K_MAB_TAB = 7;

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Offers a request at a negedge; returns at the negedge of the ISSUE cycle.
    task automatic issue(input logic wr, input logic [AW-1:0] a, input logic [LW-1:0] n);
        req_valid = 1; req_write = wr; req_addr = a; req_len = n;
        tick();
        req_valid = 0;
    endtask

    task automatic expect_start(input string tag, input logic [AW-1:0] a, input logic [LW-1:0] n,
                                input logic wr);
        chk(bus_start === 1'b1, tag, bus_start, 1);
        chk(bus_addr === a, tag, bus_addr, a);
        chk(bus_len === n, tag, bus_len, n);
        chk(bus_write === wr, tag, bus_write, wr);
        tick();
    endtask

    // Drives one data phase, samples completion outputs, advances one cycle.
    task automatic phase(input int k, input logic [DW-1:0] d,
                         output logic v, output logic [DW-1:0] o);
        tgt_ack   = (k == K_ACK) || (k == K_TAB_DISC);
        tgt_disc  = (k == K_DISC) || (k == K_TAB_DISC);
        tgt_retry = (k == K_RTY);
        tgt_abort = (k == K_TAB) || (k == K_TAB_DISC) || (k == K_MAB_TAB);
        mst_abort = (k == K_MAB) || (k == K_MAB_TAB);
        rd_data   = d;
        #1;
        v = cpl_valid;
        o = cpl_data;
        tick();
        {tgt_ack, tgt_disc, tgt_retry, tgt_abort, mst_abort} = '0;
    endtask

    task automatic read_word(input string tag, input int k, input logic [DW-1:0] d,
                             input logic ev, input logic [DW-1:0] eo);
        logic v;
        logic [DW-1:0] o;
        phase(k, d, v, o);
        chk(v === ev, tag, v, ev);
        if (ev) chk(o === eo, tag, o, eo);
    endtask

    task automatic expect_done(input string tag, input logic [1:0] s);
        chk(cpl_done === 1'b1, tag, cpl_done, 1);
        chk(cpl_status === s, tag, cpl_status, s);
        tick();
        chk(req_ready === 1'b1, tag, req_ready, 1);
    endtask

    task automatic clear_sticky();
        sta_clr_w1c = 1;
        tick();
        sta_clr_w1c = 0;
    endtask

    task automatic t_reset();
        chk(req_ready === 1'b1, "R1 ready", req_ready, 1);
        chk(bus_start === 1'b0 && bus_busy === 1'b0, "R1 bus idle", {bus_start, bus_busy}, 0);
        chk(cpl_valid === 1'b0 && cpl_done === 1'b0, "R1 cpl idle", {cpl_valid, cpl_done}, 0);
        chk(sta_rx_tabort === 1'b0, "R1 sticky", sta_rx_tabort, 0);
    endtask

    task automatic t_normal_read();
        issue(0, 16'h0100, 3);
        expect_start("R2 start", 16'h0100, 3, 0);
        read_word("R3 w0", K_ACK, 32'hA0, 1, 32'hA0);
        read_word("R3 wait state", K_WAIT, 32'hEE, 0, 0);
        read_word("R3 w1", K_ACK, 32'hA1, 1, 32'hA1);
        read_word("R3 w2", K_ACK, 32'hA2, 1, 32'hA2);
        expect_done("R3 status ok", 2'd0);
    endtask

    task automatic t_disconnect();
        issue(0, 16'h0200, 4);
        expect_start("R2 start", 16'h0200, 4, 0);
        read_word("R4 w0", K_ACK, 32'hB0, 1, 32'hB0);
        read_word("R4 disc word", K_DISC, 32'hB1, 1, 32'hB1);
        expect_start("R4 reissue", 16'h0202, 2, 0);
        read_word("R4 w2", K_ACK, 32'hB2, 1, 32'hB2);
        read_word("R4 w3", K_ACK, 32'hB3, 1, 32'hB3);
        expect_done("R4 status ok", 2'd0);
    endtask

    task automatic t_retry_write();
        issue(1, 16'h0300, 2);
        expect_start("R2 start wr", 16'h0300, 2, 1);
        read_word("R11 retry no word", K_RTY, 0, 0, 0);
        for (int i = 0; i < GAP; i++) begin
            chk(bus_start === 1'b0, "R5 gap", bus_start, 0);
            tick();
        end
        expect_start("R5 reissue", 16'h0300, 2, 1);
        read_word("R5 second retry", K_RTY, 0, 0, 0);
        for (int i = 0; i < GAP; i++) tick();
        expect_start("R5 reissue2", 16'h0300, 2, 1);
        read_word("R11 wr w0", K_ACK, 0, 0, 0);
        read_word("R11 wr w1", K_ACK, 0, 0, 0);
        chk(sta_rx_tabort === 1'b0, "R6 no error bit", sta_rx_tabort, 0);
        expect_done("R6 status ok", 2'd0);
    endtask

    task automatic t_tabort_read();
        issue(0, 16'h0400, 4);
        expect_start("R2 start", 16'h0400, 4, 0);
        read_word("R7 valid", K_ACK, 32'hC0, 1, 32'hC0);
        read_word("R7 abort phase", K_TAB, 32'hC1, 0, 0);
        for (int i = 0; i < 3; i++) read_word("R7 pad", K_WAIT, 0, 1, ONES);
        chk(sta_rx_tabort === 1'b1, "R8 set", sta_rx_tabort, 1);
        expect_done("R7 status tabort", 2'd1);
        tick();
        chk(sta_rx_tabort === 1'b1, "R8 held", sta_rx_tabort, 1);
        clear_sticky();
        chk(sta_rx_tabort === 1'b0, "R9 cleared", sta_rx_tabort, 0);
    endtask

    task automatic t_tabort_write_collide();
        issue(1, 16'h0500, 2);
        expect_start("R2 start wr", 16'h0500, 2, 1);
        read_word("R11 wr w0", K_ACK, 0, 0, 0);
        sta_clr_w1c = 1;
        read_word("R11 wr abort", K_TAB, 0, 0, 0);
        sta_clr_w1c = 0;
        chk(sta_rx_tabort === 1'b1, "R9 set wins", sta_rx_tabort, 1);
        expect_done("R8 wr status", 2'd1);
        clear_sticky();
    endtask

    task automatic t_mabort_read();
        issue(0, 16'h0600, 2);
        expect_start("R2 start", 16'h0600, 2, 0);
        read_word("R10 abort phase", K_MAB, 32'hD0, 0, 0);
        read_word("R10 pad0", K_WAIT, 0, 1, ONES);
        read_word("R10 pad1", K_WAIT, 0, 1, ONES);
        expect_done("R10 status", 2'd2);
        chk(sta_rx_tabort === 1'b0, "R10 no sticky", sta_rx_tabort, 0);
    endtask

    task automatic t_priority();
        issue(0, 16'h0700, 1);
        expect_start("R2 start", 16'h0700, 1, 0);
        read_word("R12 tab over disc", K_TAB_DISC, 32'hE0, 0, 0);
        read_word("R12 pad", K_WAIT, 0, 1, ONES);
        expect_done("R12 status tab", 2'd1);
        clear_sticky();
        issue(0, 16'h0710, 1);
        expect_start("R2 start", 16'h0710, 1, 0);
        read_word("R12 mab over tab", K_MAB_TAB, 32'hE1, 0, 0);
        read_word("R12 pad", K_WAIT, 0, 1, ONES);
        expect_done("R12 status mab", 2'd2);
        chk(sta_rx_tabort === 1'b0, "R12 no sticky", sta_rx_tabort, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        t_reset();
        t_normal_read();
        t_disconnect();
        t_retry_write();
        t_tabort_read();
        t_tabort_write_collide();
        t_mabort_read();
        t_priority();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule